// File: doc/BRIEF.md
# Microcoded Protocol Sequencer

This block is the control engine of a token-passing network controller. It walks through a microprogram stored in an on-chip read-only store. For each instruction it produces decoded control strobes that the protocol datapath consumes. A built-in test program fills the store and stands in for the real microcode.

The block uses one clock at the fast rate. A phase bit splits each instruction into two slots. In the first slot the opcode byte is fetched. In the second slot the operand byte is fetched and the instruction executes, so instructions run at half the clock rate.

Three instruction kinds exist:
- A strobe instruction pulses a set of control lines.
- A no-op holds the program counter for a programmable number of execute slots.
- A jump reloads the counter.

Opcode class 11 is reserved and only advances the counter. An external reconfiguration timeout has top priority. It restarts the program at address 0 and sets a sticky flag, which stays set until it is cleared.

Top module: `usq_core`

## Requirements
- R1: While reset is asserted and just after it, `strobe_o` is 0, `recon_flag_o` is 0 and `exec_en_o` is 0. Execution begins at address 0.
- R2: Each instruction occupies two clock cycles. `exec_en_o` is high during the cycle whose closing edge fetches the operand and executes. It alternates every cycle, including during no-op stalls.
- R3: Opcode bits [7:6] = 00 is a strobe instruction. `strobe_o` carries the operand byte for exactly one cycle after the executing edge and is 0 otherwise.
- R4: Opcode bits [7:6] = 01 is a no-op whose operand n gives the loop length in execute slots. The program counter is frozen, so the next instruction executes 2*n cycles after the no-op executes.
- R5: A no-op with operand 0 behaves like operand 1. The next instruction executes 2 cycles later.
- R6: Opcode bits [7:6] = 10 is a jump. Its target is {opcode bits [1:0], operand byte}.
- R7: A jump target at or beyond the store depth (544 words) is replaced by address 0.
- R8: `recon_timeout_i` high at an edge forces the program counter and phase to 0 and clears any pending no-op count. It overrides a jump or no-op executing at that edge. The strobe at address 0 then appears 2 cycles later.
- R9: `recon_flag_o` is set on the edge after `recon_timeout_i` is seen. It stays set until `clr_flags_i` is seen without a timeout at the same edge; a timeout wins over a simultaneous clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the instruction rate |
| rst | input | 1 | Synchronous active-high reset |
| recon_timeout_i | input | 1 | Reconfiguration timer expiry, forces restart |
| clr_flags_i | input | 1 | Clears the sticky reconfiguration flag |
| strobe_o | output | NSTB (8) | Decoded control strobes, one-cycle pulses |
| exec_en_o | output | 1 | Half-rate execute enable (phase bit) |
| recon_flag_o | output | 1 | Sticky reconfiguration flag |

## Verification
The hardest situations to reach are a timeout that lands in the middle of a no-op stall and a timeout that coincides exactly with a jump executing. Both are only visible through the timing of later strobes. The bench counts clock edges from reset and raises the timeout on a chosen edge: the second stall edge, a no-op's execute edge, and a jump's execute edge together with a clear request. At that point the scoreboard drops every expected strobe after that edge and plans a fresh program run from that edge. Any leftover or missing pulse then shows up as a mismatch.

// File: rtl/usq_pkg.sv
package usq_pkg;

  typedef enum logic [1:0] {
    OPC_STROBE = 2'b00,
    OPC_NOP    = 2'b01,
    OPC_JUMP   = 2'b10,
    OPC_RSVD   = 2'b11
  } opc_class_e;

  // Built-in test microprogram: opcode byte at even address, operand after it.
  function automatic logic [7:0] boot_word(input int unsigned a);
    case (a)
      0:       boot_word = 8'h00;  // strobe
      1:       boot_word = 8'h01;
      2:       boot_word = 8'h40;  // no-op, 3 slots
      3:       boot_word = 8'h03;
      4:       boot_word = 8'h00;  // strobe
      5:       boot_word = 8'h02;
      6:       boot_word = 8'h81;  // jump to 0x100
      7:       boot_word = 8'h00;
      256:     boot_word = 8'h00;  // strobe
      257:     boot_word = 8'h04;
      258:     boot_word = 8'h40;  // no-op, 0 slots
      259:     boot_word = 8'h00;
      260:     boot_word = 8'h00;  // strobe
      261:     boot_word = 8'h08;
      262:     boot_word = 8'h83;  // jump to 0x3FF (out of range)
      263:     boot_word = 8'hFF;
      default: boot_word = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/usq_rom.sv
module usq_rom #(
  parameter int DEPTH = 544,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  logic [7:0] mem [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign mem[i] = usq_pkg::boot_word(i);
    end
  endgenerate

  assign data = ({1'b0, addr} < (AW+1)'(DEPTH)) ? mem[addr] : 8'h00;
endmodule

// File: rtl/usq_decode.sv
module usq_decode #(
  parameter int DEPTH = 544,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [7:0]    opcode,
  input  logic [7:0]    operand,
  output logic          is_stb,
  output logic          is_nop,
  output logic          is_jmp,
  output logic [AW-1:0] target,
  output logic [7:0]    loop_len
);
  import usq_pkg::*;

  localparam int RAW_W = 10;

  opc_class_e       cls;
  logic [RAW_W-1:0] raw_tgt;
  logic             unused_opc_bits;

  assign cls             = opc_class_e'(opcode[7:6]);
  assign unused_opc_bits = ^opcode[5:2];
  assign raw_tgt         = {opcode[1:0], operand};

  always_comb begin
    is_stb = (cls == OPC_STROBE);
    is_nop = (cls == OPC_NOP);
    is_jmp = (cls == OPC_JUMP);
    loop_len = operand;
    if ({1'b0, raw_tgt} < (RAW_W+1)'(DEPTH)) target = AW'(raw_tgt);
    else                                     target = '0;
  end
endmodule

// File: rtl/usq_ctrl.sv
module usq_ctrl #(
  parameter int DEPTH = 544,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          timeout,
  input  logic [7:0]    rom_data,
  input  logic          is_nop,
  input  logic          is_jmp,
  input  logic [AW-1:0] target,
  input  logic [CW-1:0] loop_len,
  output logic [AW-1:0] pc,
  output logic          phase,
  output logic [7:0]    opcode_q,
  output logic          exec_fire
);
  logic [CW-1:0] stall_cnt;
  logic [AW-1:0] pc_inc;

  assign pc_inc    = (pc == AW'(DEPTH-1)) ? '0 : pc + 1'b1;
  assign exec_fire = phase && (stall_cnt == '0) && !timeout;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      phase     <= 1'b0;
      stall_cnt <= '0;
      opcode_q  <= 8'h00;
    end else if (timeout) begin
      pc        <= '0;
      phase     <= 1'b0;
      stall_cnt <= '0;
    end else begin
      phase <= ~phase;
      if (stall_cnt != '0) begin
        if (phase) stall_cnt <= stall_cnt - 1'b1;
      end else if (!phase) begin
        opcode_q <= rom_data;
        pc       <= pc_inc;
      end else begin
        pc <= is_jmp ? target : pc_inc;
        if (is_nop && loop_len > CW'(1)) stall_cnt <= loop_len - 1'b1;
      end
    end
  end

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (pc == '0) && !phase && (stall_cnt == '0));
  a_r4_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    (stall_cnt != '0) && !timeout |=> $stable(pc));
  a_r2_phase_toggle: assert property (@(posedge clk) disable iff (rst)
    !timeout |=> phase != $past(phase));
  a_r7_pc_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, pc} < (AW+1)'(DEPTH));
endmodule

// File: rtl/usq_core.sv
module usq_core #(
  parameter int DEPTH = 544,
  parameter int NSTB  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            recon_timeout_i,
  input  logic            clr_flags_i,
  output logic [NSTB-1:0] strobe_o,
  output logic            exec_en_o,
  output logic            recon_flag_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = 8;

  logic [AW-1:0] pc;
  logic [7:0]    rom_data;
  logic [7:0]    opcode_q;
  logic          phase, exec_fire;
  logic          is_stb, is_nop, is_jmp;
  logic [AW-1:0] target;
  logic [CW-1:0] loop_len;

  usq_rom #(.DEPTH(DEPTH), .AW(AW)) rom_i (
    .addr(pc), .data(rom_data)
  );

  usq_decode #(.DEPTH(DEPTH), .AW(AW)) dec_i (
    .opcode(opcode_q), .operand(rom_data),
    .is_stb(is_stb), .is_nop(is_nop), .is_jmp(is_jmp),
    .target(target), .loop_len(loop_len)
  );

  usq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
    .clk(clk), .rst(rst), .timeout(recon_timeout_i), .rom_data(rom_data),
    .is_nop(is_nop), .is_jmp(is_jmp), .target(target), .loop_len(loop_len),
    .pc(pc), .phase(phase), .opcode_q(opcode_q), .exec_fire(exec_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o     <= '0;
      recon_flag_o <= 1'b0;
    end else begin
      strobe_o <= (exec_fire && is_stb) ? rom_data[NSTB-1:0] : '0;
      if (recon_timeout_i)  recon_flag_o <= 1'b1;
      else if (clr_flags_i) recon_flag_o <= 1'b0;
    end
  end

  assign exec_en_o = phase;

  a_r3_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    (strobe_o != '0) |=> (strobe_o == '0));
  a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
    recon_timeout_i |=> recon_flag_o);
  a_r9_flag_hold: assert property (@(posedge clk) disable iff (rst)
    recon_flag_o && !clr_flags_i |=> recon_flag_o);
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
    clr_flags_i && !recon_timeout_i |=> !recon_flag_o);
  a_r8_quiet_restart: assert property (@(posedge clk) disable iff (rst)
    recon_timeout_i |=> (strobe_o == '0));
endmodule

// File: tb/usq_core_tb_top.sv
module usq_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tmo = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] stb;
  logic       xen, flag;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  typedef struct {
    int         at;
    logic [7:0] val;
    string      tag;
  } ev_t;
  ev_t q[$];

  usq_core dut_i (
    .clk(clk), .rst(rst), .recon_timeout_i(tmo), .clr_flags_i(clr),
    .strobe_o(stb), .exec_en_o(xen), .recon_flag_o(flag)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // Driver: drop expectations after a restart edge and plan a fresh run.
  task automatic plan_run(input int base, input int upto);
    while (q.size() > 0 && q[$].at > base) void'(q.pop_back());
    for (int k = 0; base + 20 * k + 2 <= upto; k++) begin
      q.push_back('{base + 20 * k + 2,  8'h01, (k == 0) ? "R8 restart strobe" : "R7 wrap to zero"});
      q.push_back('{base + 20 * k + 10, 8'h02, "R4 nop stall"});
      q.push_back('{base + 20 * k + 14, 8'h04, "R6 jump target"});
      q.push_back('{base + 20 * k + 18, 8'h08, "R5 zero-length nop"});
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: compare strobe pulses against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && cyc > 0 && !done) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        checks++;
        fails++;
        $display("FAIL %s missed at cycle %0d: actual=00 expected=%0h", q[0].tag, q[0].at, q[0].val);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].at == cyc) begin
        chk(q[0].tag, 32'(stb), 32'(q[0].val));
        void'(q.pop_front());
      end else if (stb != 8'h00) begin
        chk("R3 unexpected strobe", 32'(stb), 32'h0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset strobe", 32'(stb), 32'h0);
    chk("R1 reset flag", 32'(flag), 32'h0);
    chk("R1 reset phase", 32'(xen), 32'h0);
    plan_run(0, 135);
    rst = 1'b0;
    wait_cyc(1);  chk("R2 exec enable high", 32'(xen), 32'h1);
    wait_cyc(2);  chk("R2 exec enable low", 32'(xen), 32'h0);
    wait_cyc(3);  chk("R3 strobe one cycle", 32'(stb), 32'h0);
    wait_cyc(5);  chk("R2 toggles in stall", 32'(xen), 32'h1);

    // timeout on the second edge of a no-op stall
    wait_cyc(45);
    tmo = 1'b1;
    plan_run(46, 135);
    @(negedge clk);
    tmo = 1'b0;
    chk("R9 flag set", 32'(flag), 32'h1);
    chk("R8 phase reset", 32'(xen), 32'h0);

    wait_cyc(59);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9 flag cleared", 32'(flag), 32'h0);

    // timeout on a no-op execute edge
    wait_cyc(69);
    tmo = 1'b1;
    plan_run(70, 135);
    @(negedge clk);
    tmo = 1'b0;
    chk("R9 flag set again", 32'(flag), 32'h1);

    // timeout on a jump execute edge, with a simultaneous clear
    wait_cyc(81);
    tmo = 1'b1;
    clr = 1'b1;
    plan_run(82, 135);
    @(negedge clk);
    tmo = 1'b0;
    clr = 1'b0;
    chk("R9 timeout beats clear", 32'(flag), 32'h1);

    wait_cyc(130);
    chk("R9 flag sticky", 32'(flag), 32'h1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule